// File: doc/BRIEF.md
# Serial Channel Diagnostic Mode Router

This block sits between the bit-level transmit and receive paths of a serial controller and the channel's external pins. A two-bit diagnostic setting picks one of four routings: normal operation, internal loopback, automatic echo, or loopback and echo at once. The same setting decides how the carrier-detect and clear-to-send pins gate reception and transmission. A transmit-clock-invert bit and a protocol selector together decide whether transmit data is launched on the rising or the falling edge of the bit clock.

The block runs on one bit clock shared by transmitter and receiver, which the loopback routings need. Each rising edge is a bit boundary. The configuration inputs are captured at that edge and steer the bit that follows. The receive bit, both enable strobes and the transmit pin are registered, so each reflects the pins and the transmit bit sampled at the previous rising edge. A path that is not enabled idles at logic 1.

Top module: `dmr_router`

## Requirements
- R1: With mode 2'b00 (normal), rx_bit carries pin_rxd, pin_txd carries tx_bit, rx_en follows pin_cd and tx_en follows pin_cts, each one bit after the rising edge at which the inputs were sampled.
- R2: When rx_en is low, rx_bit is 1. When tx_en is low, pin_txd is 1. In normal mode, tx_en is low from the first rising edge after pin_cts falls.
- R3: With mode 2'b01 (local loopback), rx_bit carries tx_bit and pin_rxd has no effect. pin_cd still gates reception and pin_cts still gates transmission.
- R4: In mode 2'b01, cfg_loop_txd_high at 1 holds pin_txd at 1. At 0, pin_txd carries tx_bit. In the other modes this bit has no effect.
- R5: With mode 2'b10 (echo), pin_txd carries pin_rxd, tx_en is 1 whatever pin_cts is, and rx_en follows pin_cd with rx_bit carrying pin_rxd.
- R6: With mode 2'b11 (loopback and echo), rx_bit carries tx_bit, pin_txd carries pin_rxd, and rx_en and tx_en are both 1 whatever pin_cd and pin_cts are.
- R7: For cfg_proto values other than 2'b10 (2'b00 HDLC, 2'b01 transparent, 2'b11 treated the same), transmit data is launched on the falling clock edge when cfg_tx_inv is 0 and on the rising edge when it is 1.
- R8: For cfg_proto 2'b10 (Ethernet), transmit data is launched on the rising edge when cfg_tx_inv is 0 and on the falling edge when it is 1.
- R9: Configuration inputs are captured only at a rising edge and govern the outputs registered from the following rising edge onward. A change that is undone before the next rising edge has no effect.
- R10: A synchronous reset, active high, clears the captured configuration to all zeros, which is normal mode with a falling launch edge. It drives rx_en and tx_en to 0 and rx_bit and pin_txd to 1, whatever the configuration inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by transmitter and receiver |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Diagnostic routing: 00 normal, 01 loopback, 10 echo, 11 both |
| cfg_tx_inv | input | 1 | Transmit clock invert |
| cfg_proto | input | 2 | Protocol class: 10 Ethernet, others bit-synchronous |
| cfg_loop_txd_high | input | 1 | Hold the transmit pin high during local loopback |
| pin_rxd | input | 1 | Receive data pin |
| pin_cd | input | 1 | Carrier-detect pin, active high |
| pin_cts | input | 1 | Clear-to-send pin, active high |
| tx_bit | input | 1 | Transmit bit stream from the controller |
| pin_txd | output | 1 | Transmit data pin |
| rx_bit | output | 1 | Receive bit stream to the controller |
| rx_en | output | 1 | Receive enable strobe |
| tx_en | output | 1 | Transmit enable strobe |

## Verification
The bench targets the launch-edge truth table. It samples the transmit pin a quarter bit after a rising edge and again after the falling edge, so a design that swapped the Ethernet and bit-synchronous edge sense, or ignored the invert bit, shows the new bit in the wrong half. It drives opposite values on pin_rxd and tx_bit in every routing, so a design that took receive data from the pin during loopback, or did not echo during echo modes, returns the wrong bit. It also holds the modem pins low where a mode should ignore them, and sets the hold-high bit where it should have no effect. Finally, it glitches the mode between edges, changes the mode on a boundary and asserts reset with a non-zero configuration. A design that used the live mode inputs, or kept stale configuration across reset, switches routing a bit early or leaves the enables high.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

    typedef enum logic [1:0] {
        DM_NORMAL    = 2'b00,
        DM_LOOP      = 2'b01,
        DM_ECHO      = 2'b10,
        DM_LOOP_ECHO = 2'b11
    } diag_mode_e;

    typedef enum logic [1:0] {
        PR_HDLC   = 2'b00,
        PR_TRANSP = 2'b01,
        PR_ENET   = 2'b10,
        PR_RSVD   = 2'b11
    } proto_e;

    // level driven on a path that is not enabled
    localparam logic IDLE_LEVEL = 1'b1;

    typedef struct packed {
        diag_mode_e mode;
        logic       tx_inv;
        proto_e     proto;
        logic       loop_txd_high;
    } chan_cfg_t;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
    } gate_t;

    typedef struct packed {
        logic rx_bit;   // next value for the receive stream
        logic txd;      // next value for the transmit pin
    } route_t;

    function automatic logic loops_back(input diag_mode_e m);
        return m[0];
    endfunction

    function automatic logic echoes(input diag_mode_e m);
        return m[1];
    endfunction

    // Ethernet uses the opposite edge sense from the bit-synchronous protocols
    function automatic logic launch_on_falling(input logic inv, input proto_e p);
        return (p == PR_ENET) ? inv : !inv;
    endfunction

endpackage

// File: rtl/dmr_cfg_reg.sv
module dmr_cfg_reg
    import dmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg_d,
    output chan_cfg_t cfg_q
);

    // captured once per bit boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/dmr_gate.sv
module dmr_gate
    import dmr_pkg::*;
(
    input  diag_mode_e mode,
    input  logic       cd,
    input  logic       cts,
    output gate_t      gate
);

    always_comb begin
        gate.rx_en = cd;
        gate.tx_en = cts;
        case (mode)
            DM_NORMAL, DM_LOOP: begin
                gate.rx_en = cd;
                gate.tx_en = cts;
            end
            DM_ECHO: begin
                gate.rx_en = cd;
                gate.tx_en = 1'b1;
            end
            DM_LOOP_ECHO: begin
                gate.rx_en = 1'b1;
                gate.tx_en = 1'b1;
            end
            default: begin
                gate.rx_en = cd;
                gate.tx_en = cts;
            end
        endcase
    end

endmodule

// File: rtl/dmr_route.sv
module dmr_route
    import dmr_pkg::*;
(
    input  diag_mode_e mode,
    input  logic       hold_high,
    input  gate_t      gate,
    input  logic       rxd,
    input  logic       tx_bit,
    output route_t     route
);

    logic rx_src;
    logic tx_src;
    logic hold_now;

    assign rx_src   = loops_back(mode) ? tx_bit : rxd;
    assign tx_src   = echoes(mode) ? rxd : tx_bit;
    assign hold_now = (mode == DM_LOOP) && hold_high;

    always_comb begin
        route.rx_bit = gate.rx_en ? rx_src : IDLE_LEVEL;
        if (!gate.tx_en || hold_now) begin
            route.txd = IDLE_LEVEL;
        end else begin
            route.txd = tx_src;
        end
    end

endmodule

// File: rtl/dmr_launch.sv
module dmr_launch #(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_sel,
    input  logic d,
    output logic q
);

    logic rise_q;
    logic fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= RESET_LEVEL;
        end else begin
            rise_q <= d;
        end
    end

    // half-bit retimed copy for falling-edge launch
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= RESET_LEVEL;
        end else begin
            fall_q <= rise_q;
        end
    end

    assign q = fall_sel ? fall_q : rise_q;

endmodule

// File: rtl/dmr_router.sv
module dmr_router
    import dmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_tx_inv,
    input  logic [1:0] cfg_proto,
    input  logic       cfg_loop_txd_high,
    input  logic       pin_rxd,
    input  logic       pin_cd,
    input  logic       pin_cts,
    input  logic       tx_bit,
    output logic       pin_txd,
    output logic       rx_bit,
    output logic       rx_en,
    output logic       tx_en
);

    chan_cfg_t  cfg_d;
    chan_cfg_t  cfg_q;
    gate_t      gate;
    route_t     route;
    logic       launch_fall;
    logic [1:0] act_mode;

    assign cfg_d = '{
        mode:          diag_mode_e'(cfg_mode),
        tx_inv:        cfg_tx_inv,
        proto:         proto_e'(cfg_proto),
        loop_txd_high: cfg_loop_txd_high
    };

    dmr_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    dmr_gate u_gate (
        .mode (cfg_q.mode),
        .cd   (pin_cd),
        .cts  (pin_cts),
        .gate (gate)
    );

    dmr_route u_route (
        .mode      (cfg_q.mode),
        .hold_high (cfg_q.loop_txd_high),
        .gate      (gate),
        .rxd       (pin_rxd),
        .tx_bit    (tx_bit),
        .route     (route)
    );

    assign launch_fall = launch_on_falling(cfg_q.tx_inv, cfg_q.proto);

    dmr_launch #(
        .RESET_LEVEL (IDLE_LEVEL)
    ) u_launch (
        .clk      (clk),
        .rst      (rst),
        .fall_sel (launch_fall),
        .d        (route.txd),
        .q        (pin_txd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en  <= 1'b0;
            tx_en  <= 1'b0;
            rx_bit <= IDLE_LEVEL;
        end else begin
            rx_en  <= gate.rx_en;
            tx_en  <= gate.tx_en;
            rx_bit <= route.rx_bit;
        end
    end

    assign act_mode = cfg_q.mode;

endmodule

// File: rtl/dmr_router_chk.sv
module dmr_router_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] act_mode,
    input logic       pin_cd,
    input logic       pin_cts,
    input logic       tx_bit,
    input logic       rx_bit,
    input logic       rx_en,
    input logic       tx_en,
    input logic       pin_txd
);

    // R1: transmit enable tracks clear-to-send where the mode honours it
    a_r1_txen_follows_cts: assert property (@(posedge clk) disable iff (rst)
        (act_mode == 2'b00 || act_mode == 2'b01) |=> (tx_en == $past(pin_cts)));

    // R2: a disabled transmitter idles high
    a_r2_txd_idle_high: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> pin_txd);

    // R3: loopback feeds the receiver from the transmit stream
    a_r3_loop_rx_source: assert property (@(posedge clk) disable iff (rst)
        (act_mode == 2'b01 && pin_cd) |=> (rx_bit == $past(tx_bit)));

    // R5: echo modes ignore clear-to-send
    a_r5_echo_txen_on: assert property (@(posedge clk) disable iff (rst)
        act_mode[1] |=> tx_en);

    // R6: loopback plus echo ignores carrier detect
    a_r6_both_rxen_on: assert property (@(posedge clk) disable iff (rst)
        (act_mode == 2'b11) |=> rx_en);

    // R10: reset forces the idle state
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (!rx_en && !tx_en && rx_bit && pin_txd));

endmodule

bind dmr_router dmr_router_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .act_mode (act_mode),
    .pin_cd   (pin_cd),
    .pin_cts  (pin_cts),
    .tx_bit   (tx_bit),
    .rx_bit   (rx_bit),
    .rx_en    (rx_en),
    .tx_en    (tx_en),
    .pin_txd  (pin_txd)
);

// File: tb/dmr_router_test.sv
module dmr_router_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cfg_mode;
    logic       cfg_tx_inv;
    logic [1:0] cfg_proto;
    logic       cfg_loop_txd_high;
    logic       pin_rxd;
    logic       pin_cd;
    logic       pin_cts;
    logic       tx_bit;
    logic       pin_txd;
    logic       rx_bit;
    logic       rx_en;
    logic       tx_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    dmr_router uut (
        .clk               (clk),
        .rst               (rst),
        .cfg_mode          (cfg_mode),
        .cfg_tx_inv        (cfg_tx_inv),
        .cfg_proto         (cfg_proto),
        .cfg_loop_txd_high (cfg_loop_txd_high),
        .pin_rxd           (pin_rxd),
        .pin_cd            (pin_cd),
        .pin_cts           (pin_cts),
        .tx_bit            (tx_bit),
        .pin_txd           (pin_txd),
        .rx_bit            (rx_bit),
        .rx_en             (rx_en),
        .tx_en             (tx_en)
    );

    // {mode, inv, proto, hold, rxd, cd, cts, txb, exp txd, exp rx_bit, exp rx_en, exp tx_en}
    localparam int NVEC = 14;
    localparam logic [13:0] VEC [NVEC] = '{
        14'b00_0_00_0_0111_1011,
        14'b00_0_00_0_1110_0111,
        14'b00_0_00_0_0000_1100,
        14'b00_0_01_0_0100_1010,
        14'b01_0_00_0_1110_0011,
        14'b01_0_00_0_0111_1111,
        14'b01_0_00_1_0110_1011,
        14'b01_0_00_0_0010_0101,
        14'b10_0_00_0_0101_0011,
        14'b10_0_00_0_1000_1101,
        14'b11_0_00_0_0001_0111,
        14'b11_0_00_0_1000_1011,
        14'b11_0_00_1_0001_0111,
        14'b10_1_10_0_1110_1111
    };

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m, input logic h);
        case (m)
            2'b00:   return "R1";
            2'b01:   return h ? "R4" : "R3";
            2'b10:   return "R5";
            default: return h ? "R4" : "R6";
        endcase
    endfunction

    task automatic set_all(input logic [1:0] m, input logic inv, input logic [1:0] pr,
                           input logic h, input logic rxd, input logic cd,
                           input logic cts, input logic txb);
        cfg_mode = m; cfg_tx_inv = inv; cfg_proto = pr; cfg_loop_txd_high = h;
        pin_rxd = rxd; pin_cd = cd; pin_cts = cts; tx_bit = txb;
    endtask

    // R7 / R8: new bit visible a quarter bit after the rising edge only for rising launch
    task automatic launch_case(input logic inv, input logic [1:0] pr,
                               input logic exp_early, input string tag);
        set_all(2'b00, inv, pr, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #5;
        chk(tag, "txd settled low", pin_txd, 1'b0);
        tx_bit = 1'b1;
        @(posedge clk);
        #2;
        chk(tag, "txd after rising edge", pin_txd, exp_early);
        #4;
        chk(tag, "txd after falling edge", pin_txd, 1'b1);
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [13:0] v;
        // R10: reset wins over a non-zero configuration
        rst = 1'b1;
        set_all(2'b11, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #2;
        chk("R10", "rx_en in reset", rx_en, 1'b0);
        chk("R10", "tx_en in reset", tx_en, 1'b0);
        chk("R10", "rx_bit in reset", rx_bit, 1'b1);
        chk("R10", "txd in reset", pin_txd, 1'b1);
        set_all(2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #4;

        // vector table across all routings
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            set_all(v[13:12], v[11], v[10:9], v[8], v[7], v[6], v[5], v[4]);
            @(posedge clk);
            @(posedge clk);
            #5;
            chk(tag_of(v[13:12], v[8]), $sformatf("vec %0d txd", i), pin_txd, v[3]);
            chk(tag_of(v[13:12], v[8]), $sformatf("vec %0d rx_bit", i), rx_bit, v[2]);
            chk(tag_of(v[13:12], v[8]), $sformatf("vec %0d rx_en", i), rx_en, v[1]);
            chk(tag_of(v[13:12], v[8]), $sformatf("vec %0d tx_en", i), tx_en, v[0]);
        end

        // launch edge truth table
        launch_case(1'b0, 2'b00, 1'b0, "R7");
        launch_case(1'b1, 2'b00, 1'b1, "R7");
        launch_case(1'b0, 2'b01, 1'b0, "R7");
        launch_case(1'b0, 2'b10, 1'b1, "R8");
        launch_case(1'b1, 2'b10, 1'b0, "R8");

        // R2: clear-to-send drop disables transmit one bit later, pin idles high
        set_all(2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        repeat (2) @(posedge clk);
        #5;
        chk("R1", "tx_en with cts high", tx_en, 1'b1);
        chk("R1", "txd carries tx_bit", pin_txd, 1'b0);
        pin_cts = 1'b0;
        @(posedge clk);
        #2;
        chk("R2", "tx_en after cts drop", tx_en, 1'b0);
        #4;
        chk("R2", "txd idle after cts drop", pin_txd, 1'b1);
        pin_cd = 1'b0;
        @(posedge clk);
        #2;
        chk("R2", "rx_en after cd drop", rx_en, 1'b0);
        chk("R2", "rx_bit idle after cd drop", rx_bit, 1'b1);

        // R9: mode only taken at a bit boundary
        set_all(2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        repeat (2) @(posedge clk);
        #5;
        chk("R9", "rx_bit normal before glitch", rx_bit, 1'b0);
        cfg_mode = 2'b01;
        #2;
        cfg_mode = 2'b00;
        repeat (2) @(posedge clk);
        #2;
        chk("R9", "rx_bit after mid-bit glitch", rx_bit, 1'b0);
        cfg_mode = 2'b01;
        @(posedge clk);
        #2;
        chk("R9", "rx_bit one bit after change", rx_bit, 1'b0);
        @(posedge clk);
        #2;
        chk("R9", "rx_bit two bits after change", rx_bit, 1'b1);

        // R10: mid-run reset clears captured configuration
        set_all(2'b11, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (2) @(posedge clk);
        #5;
        chk("R6", "rx_en with cd low", rx_en, 1'b1);
        chk("R6", "tx_en with cts low", tx_en, 1'b1);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        chk("R10", "rx_en mid-run reset", rx_en, 1'b0);
        chk("R10", "tx_en mid-run reset", tx_en, 1'b0);
        chk("R10", "txd mid-run reset", pin_txd, 1'b1);
        rst = 1'b0;
        @(posedge clk);
        #2;
        chk("R10", "rx_en uses cleared mode first bit", rx_en, 1'b0);
        @(posedge clk);
        #2;
        chk("R9", "rx_en once mode captured", rx_en, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule